// File: doc/BRIEF.md
# Nanosecond-to-Cycle Bus Timing Converter

This block turns seven external-bus timing intervals, each given in nanoseconds, into cycle counts ready to load into a programmable bus controller. It takes the core clock rate in whole MHz and works out how many clock periods each interval needs, always rounding up. Each count is then stored as one less than its value, because the target fields count from zero. If the strobe-width count is too large for its field, every count is halved, rounding up, and a scale factor doubles. This repeats until the strobe count fits or the factor reaches 8.

A request is one beat on a valid/ready input. The beat carries the clock rate, the seven intervals, and an optional mode number. When the mode is used, a built-in table of standard timings supplies the setup, strobe and end-hold intervals. The block works on one request at a time. It holds `in_ready` low from the accepting edge until the cycle in which it raises `done`, so a request offered while it is busy waits, with no effect on the job in progress. The result side cannot be stalled. `done` is a single-cycle pulse, and the result outputs then hold their values until the next request is accepted.

Top module: `ns_cycle_converter`

## Requirements
- R1: Each interval k, taken from `ns_in[8k+7:8k]`, gives q = ceil(ns × MHz / 1000) clock cycles.
- R2: The count reported for an interval is q−1 when q is nonzero. When q is zero it is 0.
- R3: While the strobe count (interval 1) is 64 or more and fewer than 3 halvings have been done, every count becomes ceil(x/2) and `scale_mult` doubles. It starts at 1 and can reach 2, 4 or 8.
- R4: Only the strobe count decides whether halving happens. A larger count on any other interval causes no halving. A count that does not fit its 6-bit field is reported as 63.
- R5: `scale_code` encodes a factor of 1 as 1, 2 as 2, 4 as 0, and 8 as 3.
- R6: If the strobe count is still 64 or more after three halvings, `overflow` is 1 and the strobe field reads 63. Otherwise `overflow` is 0.
- R7: With `use_mode` set, intervals 0, 1 and 6 (setup, strobe, end-hold) come from a table, in ns. Intervals 2 to 5 still come from `ns_in`. The table is:

  | Mode | Setup | Strobe | End-hold |
  |---|---|---|---|
  | 0 | 70 | 165 | 20 |
  | 1 | 50 | 125 | 15 |
  | 2 | 30 | 100 | 10 |
  | 3 | 30 | 80 | 10 |
  | 4 | 25 | 70 | 10 |
  | 5 | 15 | 65 | 10 |
  | 6 | 10 | 55 | 10 |
- R8: Mode number 7 gives the mode 0 timings.
- R9: After reset, `in_ready` is 1 and `done` and `overflow` are 0. A request is taken only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 until `done` rises. A request offered while `in_ready` is 0 produces no result.
- R10: `done` is high for exactly one cycle. This is 155 + h clock edges after the accepting edge, where h is the number of halvings. All outputs hold their values from then until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_mhz | input | 11 | Clock rate in whole MHz |
| ns_in | input | 56 | Seven 8-bit intervals in ns; interval k in bits [8k+7:8k] |
| use_mode | input | 1 | Take setup, strobe and end-hold from the mode table |
| mode_sel | input | 3 | Mode number 0 to 7 |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle and able to accept a request |
| cnt_out | output | 42 | Seven 6-bit counts; interval k in bits [6k+5:6k] |
| scale_mult | output | 4 | Scale factor 1, 2, 4 or 8 |
| scale_code | output | 2 | Encoded scale factor |
| overflow | output | 1 | Strobe count did not fit at factor 8 |
| done | output | 1 | One-cycle pulse: results valid |

## Verification
Each conversion takes one divider start cycle, 20 shift-subtract steps and one store cycle. The seven intervals together therefore take 154 edges, then one edge per halving and one exit edge. `done` thus rises 155 + h edges after acceptance. The bench records a free-running cycle count at the accepting edge and again when it sees `done`, sampling at the falling edge. It compares the gap with the figure its own model predicts from the same h. An item is popped from the scoreboard only on a `done` pulse. So a pulse with no queued item, including one that a refused request might cause, shows up as a mismatch, and the held outputs are compared again several cycles after the pulse.

// File: rtl/ns_conv_pkg.sv
package ns_conv_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIT
  } conv_state_e;

  // Non-monotonic field encoding of the scale factor 2**doublings.
  function automatic logic [1:0] scale_encode(input int unsigned doublings);
    case (doublings)
      0:       return 2'd1;
      1:       return 2'd2;
      2:       return 2'd0;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/ns_mode_table.sv
module ns_mode_table
  import ns_conv_pkg::*;
#(
  parameter int NS_W = 8
) (
  input  logic [MODE_W-1:0] mode_sel,
  output logic [NS_W-1:0]   setup_ns,
  output logic [NS_W-1:0]   strobe_ns,
  output logic [NS_W-1:0]   hold_ns
);

  always_comb begin
    case (mode_sel)
      3'd1: begin setup_ns = NS_W'(50); strobe_ns = NS_W'(125); hold_ns = NS_W'(15); end
      3'd2: begin setup_ns = NS_W'(30); strobe_ns = NS_W'(100); hold_ns = NS_W'(10); end
      3'd3: begin setup_ns = NS_W'(30); strobe_ns = NS_W'(80);  hold_ns = NS_W'(10); end
      3'd4: begin setup_ns = NS_W'(25); strobe_ns = NS_W'(70);  hold_ns = NS_W'(10); end
      3'd5: begin setup_ns = NS_W'(15); strobe_ns = NS_W'(65);  hold_ns = NS_W'(10); end
      3'd6: begin setup_ns = NS_W'(10); strobe_ns = NS_W'(55);  hold_ns = NS_W'(10); end
      // mode 0 and any unknown number (R8)
      default: begin setup_ns = NS_W'(70); strobe_ns = NS_W'(165); hold_ns = NS_W'(20); end
    endcase
  end

endmodule

// File: rtl/ns_cycle_divider.sv
module ns_cycle_divider #(
  parameter int P_W     = 20,
  parameter int DIVISOR = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [P_W-1:0] dividend,
  output logic           done,
  output logic [P_W-1:0] quotient
);

  localparam int T_W = $clog2(DIVISOR) + 1;   // trial remainder width
  localparam int R_W = T_W - 1;               // held remainder width
  localparam int C_W = $clog2(P_W + 1);

  logic [P_W-1:0] dend_q;
  logic [R_W-1:0] rem_q;
  logic [C_W-1:0] left_q;
  logic           busy_q;
  logic [T_W-1:0] trial;
  logic [T_W-1:0] trial_sub;
  logic           fits;

  assign trial     = {rem_q, dend_q[P_W-1]};
  assign fits      = trial >= T_W'(DIVISOR);
  assign trial_sub = fits ? (trial - T_W'(DIVISOR)) : trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dend_q   <= '0;
      rem_q    <= '0;
      left_q   <= '0;
      busy_q   <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
    end else if (start && !busy_q) begin
      dend_q   <= dividend;
      rem_q    <= '0;
      left_q   <= C_W'(P_W);
      busy_q   <= 1'b1;
      done     <= 1'b0;
      quotient <= '0;
    end else if (busy_q) begin
      dend_q   <= {dend_q[P_W-2:0], 1'b0};
      rem_q    <= trial_sub[R_W-1:0];
      quotient <= {quotient[P_W-2:0], fits};
      left_q   <= left_q - 1'b1;
      if (left_q == C_W'(1)) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/ns_cycle_converter.sv
module ns_cycle_converter
  import ns_conv_pkg::*;
#(
  parameter int NS_W          = 8,
  parameter int MHZ_W         = 11,
  parameter int CNT_W         = 6,
  parameter int N_INT         = 7,
  parameter int SETUP_IDX     = 0,
  parameter int STROBE_IDX    = 1,
  parameter int HOLD_IDX      = 6,
  parameter int MAX_DOUBLINGS = 3,
  parameter int DIVISOR       = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MHZ_W-1:0]         clk_mhz,
  input  logic [N_INT*NS_W-1:0]    ns_in,
  input  logic                     use_mode,
  input  logic [MODE_W-1:0]        mode_sel,
  input  logic                     in_valid,
  output logic                     in_ready,
  output logic [N_INT*CNT_W-1:0]   cnt_out,
  output logic [MAX_DOUBLINGS:0]   scale_mult,
  output logic [1:0]               scale_code,
  output logic                     overflow,
  output logic                     done
);

  localparam int P_W       = NS_W + MHZ_W + 1;
  localparam int IDX_W     = $clog2(N_INT);
  localparam int SH_W      = $clog2(MAX_DOUBLINGS + 1);
  localparam int FIT_LIMIT = 1 << CNT_W;
  localparam int FIELD_MAX = FIT_LIMIT - 1;

  conv_state_e    state_q;
  logic [IDX_W-1:0] idx_q;
  logic [SH_W-1:0]  shift_q;
  logic [NS_W-1:0]  lat_ns   [N_INT];
  logic [NS_W-1:0]  sel_ns   [N_INT];
  logic [P_W-1:0]   work_q   [N_INT];
  logic [MHZ_W-1:0] lat_mhz;
  logic [NS_W-1:0]  tbl_setup, tbl_strobe, tbl_hold;
  logic [P_W-1:0]   dividend;
  logic [P_W-1:0]   quotient;
  logic             div_start, div_done;
  logic             accept, strobe_big, can_halve;

  ns_mode_table #(.NS_W(NS_W)) i_mode_table (
    .mode_sel  (mode_sel),
    .setup_ns  (tbl_setup),
    .strobe_ns (tbl_strobe),
    .hold_ns   (tbl_hold)
  );

  // Interval source selection: table entries replace three intervals.
  for (genvar k = 0; k < N_INT; k++) begin : g_sel
    if (k == SETUP_IDX) begin : g_setup
      assign sel_ns[k] = use_mode ? tbl_setup : ns_in[k*NS_W +: NS_W];
    end else if (k == STROBE_IDX) begin : g_strobe
      assign sel_ns[k] = use_mode ? tbl_strobe : ns_in[k*NS_W +: NS_W];
    end else if (k == HOLD_IDX) begin : g_hold
      assign sel_ns[k] = use_mode ? tbl_hold : ns_in[k*NS_W +: NS_W];
    end else begin : g_raw
      assign sel_ns[k] = ns_in[k*NS_W +: NS_W];
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign div_start = (state_q == ST_ISSUE);
  // ceil(ns*MHz/DIVISOR) as floor((ns*MHz + DIVISOR-1)/DIVISOR)
  assign dividend  = P_W'(lat_ns[idx_q]) * P_W'(lat_mhz) + P_W'(DIVISOR - 1);

  ns_cycle_divider #(.P_W(P_W), .DIVISOR(DIVISOR)) i_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (dividend),
    .done     (div_done),
    .quotient (quotient)
  );

  assign strobe_big = work_q[STROBE_IDX] >= P_W'(FIT_LIMIT);
  assign can_halve  = shift_q != SH_W'(MAX_DOUBLINGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      shift_q  <= '0;
      lat_mhz  <= '0;
      overflow <= 1'b0;
      done     <= 1'b0;
      for (int k = 0; k < N_INT; k++) begin
        lat_ns[k] <= '0;
        work_q[k] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            lat_mhz  <= clk_mhz;
            idx_q    <= '0;
            shift_q  <= '0;
            overflow <= 1'b0;
            for (int k = 0; k < N_INT; k++) lat_ns[k] <= sel_ns[k];
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            work_q[idx_q] <= (quotient == '0) ? '0 : quotient - 1'b1;
            if (idx_q == IDX_W'(N_INT - 1)) begin
              state_q <= ST_FIT;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_FIT: begin
          if (strobe_big && can_halve) begin
            for (int k = 0; k < N_INT; k++)
              work_q[k] <= (work_q[k] >> 1) + P_W'(work_q[k][0]);
            shift_q <= shift_q + 1'b1;
          end else begin
            overflow <= strobe_big;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Field packing with saturation at the all-ones code.
  for (genvar k = 0; k < N_INT; k++) begin : g_out
    assign cnt_out[k*CNT_W +: CNT_W] =
      (work_q[k] > P_W'(FIELD_MAX)) ? {CNT_W{1'b1}} : work_q[k][CNT_W-1:0];
  end

  assign scale_mult = (MAX_DOUBLINGS+1)'(1) << shift_q;
  assign scale_code = scale_encode(int'(shift_q));

endmodule

// File: rtl/ns_cycle_converter_chk.sv
module ns_cycle_converter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       done,
  input logic       overflow,
  input logic [1:0] scale_code
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  // R6
  overflow_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (scale_code == 2'd3));

endmodule

bind ns_cycle_converter ns_cycle_converter_chk i_ns_cycle_converter_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .done       (done),
  .overflow   (overflow),
  .scale_code (scale_code)
);

// File: tb/test_ns_cycle_converter.sv
module test_ns_cycle_converter;

  typedef struct {
    logic [41:0] cnts;
    logic [3:0]  mult;
    logic [1:0]  code;
    logic        ovf;
    int          lat;
    int          t_acc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] clk_mhz = '0;
  logic [55:0] ns_in = '0;
  logic        use_mode = 1'b0;
  logic [2:0]  mode_sel = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [41:0] cnt_out;
  logic [3:0]  scale_mult;
  logic [1:0]  scale_code;
  logic        overflow;
  logic        done;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   n_done = 0;
  int   n_sent = 0;
  exp_t sb[$];
  exp_t last_exp;

  ns_cycle_converter i_ns_cycle_converter (
    .clk(clk), .rst_n(rst_n), .clk_mhz(clk_mhz), .ns_in(ns_in),
    .use_mode(use_mode), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_ready(in_ready), .cnt_out(cnt_out), .scale_mult(scale_mult),
    .scale_code(scale_code), .overflow(overflow), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [55:0] pack7(int a, int b, int c, int d, int e, int f, int g);
    return {8'(g), 8'(f), 8'(e), 8'(d), 8'(c), 8'(b), 8'(a)};
  endfunction

  function automatic exp_t model(int mhz, logic [55:0] v, bit um, int md, string tag);
    exp_t r;
    int ns[7];
    int c[7];
    int sh;
    int tbl_s[8] = '{70, 50, 30, 30, 25, 15, 10, 70};
    int tbl_t[8] = '{165, 125, 100, 80, 70, 65, 55, 165};
    int tbl_h[8] = '{20, 15, 10, 10, 10, 10, 10, 20};
    for (int k = 0; k < 7; k++) ns[k] = int'(v[k*8 +: 8]);
    if (um) begin
      ns[0] = tbl_s[md];
      ns[1] = tbl_t[md];
      ns[6] = tbl_h[md];
    end
    for (int k = 0; k < 7; k++) begin
      int q;
      q = (ns[k] * mhz + 999) / 1000;
      c[k] = (q == 0) ? 0 : q - 1;
    end
    sh = 0;
    while (c[1] >= 64 && sh < 3) begin
      for (int k = 0; k < 7; k++) c[k] = (c[k] + 1) / 2;
      sh++;
    end
    r.ovf = (c[1] >= 64);
    for (int k = 0; k < 7; k++) r.cnts[k*6 +: 6] = (c[k] > 63) ? 6'd63 : 6'(c[k]);
    r.mult = 4'(1 << sh);
    case (sh)
      0: r.code = 2'd1;
      1: r.code = 2'd2;
      2: r.code = 2'd0;
      default: r.code = 2'd3;
    endcase
    r.lat = 7 * 22 + 1 + sh;
    r.t_acc = 0;
    r.tag = tag;
    return r;
  endfunction

  task automatic send(int mhz, logic [55:0] v, bit um, int md, string tag);
    exp_t e;
    e = model(mhz, v, um, md, tag);
    @(negedge clk);
    clk_mhz = 11'(mhz); ns_in = v; use_mode = um; mode_sel = 3'(md); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    e.t_acc = cyc;
    sb.push_back(e);
    n_sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops one expected item per done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (sb.size() == 0) begin
        check("R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "counts", cnt_out, e.cnts);
        check("R5", "scale_code", scale_code, e.code);
        check("R3", "scale_mult", scale_mult, e.mult);
        check("R6", "overflow", overflow, e.ovf);
        check("R10", "latency", cyc - e.t_acc, e.lat);
        last_exp = e;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "reset in_ready", in_ready, 1);
    check("R9", "reset done", done, 0);
    check("R9", "reset overflow", overflow, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2: plain conversion, no halving, factor 1
    send(100, pack7(30, 100, 70, 15, 5, 30, 20), 1'b0, 0, "R1");
    drain();
    // R2: zero stays zero, ceiling edge 999 -> 1 cycle -> 0
    send(333, pack7(0, 3, 0, 1, 0, 6, 0), 1'b0, 0, "R2");
    send(334, pack7(0, 3, 0, 1, 0, 6, 0), 1'b0, 0, "R2");
    drain();
    // R7 R3: mode 0 at 1000 MHz, two halvings, factor 4 (code 0)
    send(1000, pack7(0, 0, 0, 30, 5, 30, 0), 1'b1, 0, "R7");
    // R8: mode 7 behaves as mode 0
    send(1000, pack7(0, 0, 0, 30, 5, 30, 0), 1'b1, 7, "R8");
    // R7: table entries at factor 2 and other modes
    send(1000, pack7(0, 0, 25, 10, 5, 30, 0), 1'b1, 4, "R7");
    send(1500, pack7(0, 0, 20, 5, 5, 20, 0), 1'b1, 6, "R7");
    send(600, pack7(0, 0, 0, 20, 5, 30, 0), 1'b1, 1, "R7");
    drain();
    // R4: large setup does not trigger halving; setup saturates
    send(1000, pack7(200, 10, 0, 0, 0, 0, 0), 1'b0, 0, "R4");
    drain();
    check("R4", "setup saturated", cnt_out[5:0], 63);
    check("R4", "no halving", scale_mult, 1);
    // R5: factor 8 without overflow
    send(2000, pack7(20, 200, 10, 10, 5, 30, 20), 1'b0, 0, "R5");
    drain();
    // R6: overflow at factor 8
    send(2000, pack7(70, 255, 10, 10, 5, 30, 20), 1'b0, 0, "R6");
    drain();
    check("R6", "strobe saturated", cnt_out[11:6], 63);

    // R9: request offered while busy is ignored
    send(100, pack7(30, 100, 70, 15, 5, 30, 20), 1'b0, 0, "R9");
    @(negedge clk);
    clk_mhz = 11'd2000; ns_in = pack7(255, 255, 255, 255, 255, 255, 255); in_valid = 1'b1;
    repeat (30) @(negedge clk);
    check("R9", "busy in_ready", in_ready, 0);
    in_valid = 1'b0;
    drain();
    repeat (200) @(negedge clk);
    check("R9", "done count", n_done, n_sent);

    // R10: outputs held after done
    check("R10", "held counts", cnt_out, last_exp.cnts);
    check("R10", "held code", scale_code, last_exp.code);
    check("R10", "done low", done, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule